// File: doc/BRIEF.md
# Serial Port FIFO Threshold Controller

This block holds the transmit and receive character queues of a serial port and the write-only configuration register that sets them up. The host pushes transmit characters and pops received ones; the serializer does the opposite. From the two occupancy counts and the register contents the block derives a received-data interrupt, a transmit threshold interrupt, two active-low DMA request lines and an RTS line for automatic flow control.

The register is written through a single strobe with one byte of data. It holds an enable, a DMA signalling mode and two trigger codes. Its two queue-clear bits act once and are never stored. Changing the enable clears both queues. With the queues disabled each direction degenerates to a one-character holding register.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset every register field is 0: both queues are disabled and empty, `rx_avail_irq`=0, `tx_thr_irq`=1, `dma_tx_req_n`=0, `dma_rx_req_n`=1, `rts_n`=0, both overrun pulses are 0 and both read data outputs are 0.
- R2: With bit 0 set, characters leave each queue in push order, up to DEPTH entries. A pop is accepted when the queue is not empty, and the read data output shows the popped character from the clock edge that accepts the pop.
- R3: `rx_avail_irq` is high while receive occupancy is at or above the receive level set by bits [7:6]: 00 gives 1, 01 gives DEPTH/4, 10 gives DEPTH/2 and 11 gives DEPTH-2. With the queues disabled the level is 1.
- R4: `tx_thr_irq` is high while transmit occupancy is at or below the transmit level set by bits [5:4]: 00 gives 0, 01 gives 2, 10 gives DEPTH/4 and 11 gives DEPTH/2. The field is used only when the queues are enabled and `prog_empty_en` is high; otherwise the level is 0.
- R5: While `prog_empty_en` is low, a register write leaves bits [5:4] unchanged. The stored code takes effect again once the input returns high.
- R6: A write with bit 2 set empties the transmit queue, and a write with bit 1 set empties the receive queue, at that clock edge. The clear takes priority over a push or pop in the same cycle. It is not stored, so later pushes are accepted. Emptying the receive queue releases the receive DMA request.
- R7: A write whose bit 0 differs from the stored enable empties both queues. A write that repeats the stored value leaves their contents intact.
- R8: With bit 0 clear, each queue holds at most one character. A second push overruns, and the receive interrupt fires on one character.
- R9: Bit 3 selects the DMA mode. In mode 0, `dma_rx_req_n` is low while the receive queue is not empty, and `dma_tx_req_n` is low while the transmit queue is empty. In mode 1 they are low exactly when the R3 and R4 conditions hold.
- R10: `rts_n` is high when `auto_flow_en` is high and the R3 condition holds, and low otherwise.
- R11: A push to a full queue is dropped and leaves the contents unchanged. The matching overrun output is high for the one cycle after that edge.
- R12: A pop from an empty queue leaves the read data output and the occupancy unchanged.
- R13: A push and a pop in the same cycle on a full enabled queue are both accepted, with no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data (enable, clears, mode, triggers) |
| prog_empty_en | input | 1 | Enables the programmable transmit threshold |
| auto_flow_en | input | 1 | Enables automatic RTS control |
| tx_push | input | 1 | Host writes a transmit character |
| tx_wdata | input | DW | Transmit character |
| tx_pop | input | 1 | Serializer takes a transmit character |
| tx_rdata | output | DW | Last character taken from the transmit queue |
| rx_push | input | 1 | Serializer delivers a received character |
| rx_wdata | input | DW | Received character |
| rx_pop | input | 1 | Host reads a received character |
| rx_rdata | output | DW | Last character taken from the receive queue |
| rx_avail_irq | output | 1 | Received-data threshold interrupt |
| tx_thr_irq | output | 1 | Transmit threshold interrupt |
| dma_tx_req_n | output | 1 | Transmit DMA request, active low |
| dma_rx_req_n | output | 1 | Receive DMA request, active low |
| rts_n | output | 1 | Flow control output, high means stop sending |
| tx_ovr | output | 1 | Transmit overrun pulse |
| rx_ovr | output | 1 | Receive overrun pulse |

## Verification
A register write that clears a queue can land in the same cycle as a push or pop on that queue, and the clear must win. The bench provokes this directly with a receive push issued together with a receive-clear write. The random phase also mixes clear writes and enable changes into dense push and pop traffic. A per-cycle reference model, which applies the clear first and drops the push, judges every output, including the read data and the DMA lines on the following cycle.

// File: rtl/ufc_pkg.sv
// Package: shared configuration type and trigger level decoders for the
// serial port FIFO threshold controller. Assumes depth is a power of two >= 16.
package ufc_pkg;

    typedef struct packed {
        logic [1:0] rx_trig;
        logic [1:0] tx_trig;
        logic       dma_mode;
        logic       fifo_en;
    } ufc_cfg_t;

    // Receive level in characters for a trigger code.
    function automatic int unsigned rx_level(input logic [1:0] code, input int unsigned depth);
        case (code)
            2'b00:   return 1;
            2'b01:   return depth / 4;
            2'b10:   return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

    // Transmit level in characters for a trigger code.
    function automatic int unsigned tx_level(input logic [1:0] code, input int unsigned depth);
        case (code)
            2'b00:   return 0;
            2'b01:   return 2;
            2'b10:   return depth / 4;
            default: return depth / 2;
        endcase
    endfunction

endpackage

// File: rtl/ufc_ctrl_reg.sv
// Module: write-only configuration register. It stores the enable, DMA mode
// and trigger codes, and turns the clear bits and enable changes into
// one-cycle queue clear strobes. Assumes one write per strobe cycle.
module ufc_ctrl_reg
    import ufc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_wdata,
    input  logic       prog_empty_en,
    output ufc_cfg_t   cfg,
    output logic       tx_flush,
    output logic       rx_flush
);

    logic en_flip;

    // Store the configuration fields; the transmit code is gated by the mode input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (cfg_wr) begin
            cfg.fifo_en  <= cfg_wdata[0];
            cfg.dma_mode <= cfg_wdata[3];
            cfg.rx_trig  <= cfg_wdata[7:6];
            if (prog_empty_en) begin
                cfg.tx_trig <= cfg_wdata[5:4];
            end
        end
    end

    // Derive the single-cycle clear strobes; nothing of them is stored.
    always_comb begin
        en_flip  = cfg_wr && (cfg_wdata[0] != cfg.fifo_en);
        tx_flush = (cfg_wr && cfg_wdata[2]) || en_flip;
        rx_flush = (cfg_wr && cfg_wdata[1]) || en_flip;
    end

endmodule

// File: rtl/ufc_fifo.sv
// Module: one character queue with occupancy count. Capacity is DEPTH when
// enabled, else 1. A clear beats push and pop; a pop from empty keeps the
// read data; a rejected push raises a registered one-cycle overrun.
module ufc_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] cnt,
    output logic          ovr
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cap;
    logic          pop_ok, push_ok;

    // Decide which strobes are accepted this cycle.
    always_comb begin
        cap     = en ? CW'(DEPTH) : CW'(1);
        pop_ok  = pop && (cnt != '0);
        push_ok = push && ((cnt < cap) || pop_ok);
    end

    // Write the storage array on an accepted push.
    always_ff @(posedge clk) begin
        if (push_ok && !flush) begin
            mem[wptr] <= wdata;
        end
    end

    // Move pointers, count, read data and the overrun pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            cnt   <= '0;
            ovr   <= 1'b0;
            rdata <= '0;
        end else if (flush) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
            ovr  <= 1'b0;
        end else begin
            if (push_ok) wptr <= wptr + AW'(1);
            if (pop_ok) begin
                rptr  <= rptr + AW'(1);
                rdata <= mem[rptr];
            end
            cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
            ovr <= push && !push_ok;
        end
    end

endmodule

// File: rtl/ufc_thresh.sv
// Module: decodes trigger codes into levels and compares them with the two
// occupancy counts to form interrupts, DMA requests and RTS. Purely combinational.
module ufc_thresh
    import ufc_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
    input  ufc_cfg_t      cfg,
    input  logic          prog_empty_en,
    input  logic          auto_flow_en,
    input  logic [CW-1:0] tx_cnt,
    input  logic [CW-1:0] rx_cnt,
    output logic          rx_avail_irq,
    output logic          tx_thr_irq,
    output logic          dma_tx_req_n,
    output logic          dma_rx_req_n,
    output logic          rts_n
);

    logic [CW-1:0] rx_lvl, tx_lvl;
    logic          rx_hit, tx_hit;

    // Compute levels and the resulting output conditions.
    always_comb begin
        rx_lvl = cfg.fifo_en ? CW'(rx_level(cfg.rx_trig, DEPTH)) : CW'(1);
        tx_lvl = (cfg.fifo_en && prog_empty_en) ? CW'(tx_level(cfg.tx_trig, DEPTH)) : '0;
        rx_hit = rx_cnt >= rx_lvl;
        tx_hit = tx_cnt <= tx_lvl;
        rx_avail_irq = rx_hit;
        tx_thr_irq   = tx_hit;
        dma_rx_req_n = !(cfg.dma_mode ? rx_hit : (rx_cnt != '0));
        dma_tx_req_n = !(cfg.dma_mode ? tx_hit : (tx_cnt == '0));
        rts_n        = auto_flow_en && rx_hit;
    end

endmodule

// File: rtl/uart_fifo_ctl.sv
// Module: top of the serial port FIFO threshold controller. It joins the
// configuration register, the two queues and the threshold decoder.
// Assumes DEPTH is a power of two of at least 16.
module uart_fifo_ctl
    import ufc_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [7:0]    cfg_wdata,
    input  logic          prog_empty_en,
    input  logic          auto_flow_en,
    input  logic          tx_push,
    input  logic [DW-1:0] tx_wdata,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_rdata,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_wdata,
    input  logic          rx_pop,
    output logic [DW-1:0] rx_rdata,
    output logic          rx_avail_irq,
    output logic          tx_thr_irq,
    output logic          dma_tx_req_n,
    output logic          dma_rx_req_n,
    output logic          rts_n,
    output logic          tx_ovr,
    output logic          rx_ovr
);

    localparam int unsigned CW = $clog2(DEPTH) + 1;

    ufc_cfg_t      cfg;
    logic          tx_flush, rx_flush, fifo_en;
    logic [CW-1:0] tx_cnt, rx_cnt;

    assign fifo_en = cfg.fifo_en;

    ufc_ctrl_reg u_reg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .prog_empty_en(prog_empty_en), .cfg(cfg),
        .tx_flush(tx_flush), .rx_flush(rx_flush)
    );

    ufc_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
        .clk(clk), .rst_n(rst_n), .en(fifo_en), .flush(tx_flush),
        .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
        .rdata(tx_rdata), .cnt(tx_cnt), .ovr(tx_ovr)
    );

    ufc_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
        .clk(clk), .rst_n(rst_n), .en(fifo_en), .flush(rx_flush),
        .push(rx_push), .wdata(rx_wdata), .pop(rx_pop),
        .rdata(rx_rdata), .cnt(rx_cnt), .ovr(rx_ovr)
    );

    ufc_thresh #(.DEPTH(DEPTH)) u_thr (
        .cfg(cfg), .prog_empty_en(prog_empty_en), .auto_flow_en(auto_flow_en),
        .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
        .rx_avail_irq(rx_avail_irq), .tx_thr_irq(tx_thr_irq),
        .dma_tx_req_n(dma_tx_req_n), .dma_rx_req_n(dma_rx_req_n), .rts_n(rts_n)
    );

endmodule

// File: rtl/ufc_checker.sv
// Module: property checker for uart_fifo_ctl, attached by bind. Watches the
// register write strobe, the stored enable and both occupancy counts.
module ufc_checker #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_wr,
    input logic [1:0]    clr_bits,
    input logic          fen,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt,
    input logic          rx_push,
    input logic          rx_ovr,
    input logic          rx_avail_irq
);

    a_r11_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

    a_r11_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovr |-> $past(rx_push));

    a_r6_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && clr_bits[1]) |=> (rx_cnt == '0));

    a_r7_en_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (clr_bits[0] != fen)) |=> (tx_cnt == '0) && (rx_cnt == '0));

    a_r8_single_holder: assert property (@(posedge clk) disable iff (!rst_n)
        !fen |-> (rx_cnt <= CW'(1)) && (tx_cnt <= CW'(1)));

    a_r3_empty_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == '0) |-> !rx_avail_irq);

endmodule

bind uart_fifo_ctl ufc_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .clr_bits(cfg_wdata[1:0]),
    .fen(fifo_en), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .rx_push(rx_push),
    .rx_ovr(rx_ovr), .rx_avail_irq(rx_avail_irq)
);

// File: tb/tb_uart_fifo_ctl.sv
`timescale 1ns/1ps
// Bench: per-cycle reference model plus directed corner cases and seeded random traffic.
module tb_uart_fifo_ctl;

    localparam int D = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       prog_en = 1'b0, afc_en = 1'b0;
    logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] tx_wdata = '0, rx_wdata = '0;
    logic [7:0] tx_rdata, rx_rdata;
    logic       rx_avail_irq, tx_thr_irq, dma_tx_req_n, dma_rx_req_n, rts_n, tx_ovr, rx_ovr;

    int checks = 0, fails = 0;

    // reference model state
    logic [7:0] tq[$], rq[$];
    bit         m_fen, m_dm;
    bit [1:0]   m_tet, m_rt;
    logic [7:0] m_trd = '0, m_rrd = '0;
    bit         m_tovr, m_rovr;

    always #2 clk = ~clk;

    uart_fifo_ctl #(.DEPTH(D), .DW(8)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .prog_empty_en(prog_en), .auto_flow_en(afc_en),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .rx_avail_irq(rx_avail_irq), .tx_thr_irq(tx_thr_irq),
        .dma_tx_req_n(dma_tx_req_n), .dma_rx_req_n(dma_rx_req_n), .rts_n(rts_n),
        .tx_ovr(tx_ovr), .rx_ovr(rx_ovr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int rxl();
        if (!m_fen) return 1;
        case (m_rt) 0: return 1; 1: return D / 4; 2: return D / 2; default: return D - 2; endcase
    endfunction

    function automatic int txl();
        if (!m_fen || !prog_en) return 0;
        case (m_tet) 0: return 0; 1: return 2; 2: return D / 4; default: return D / 2; endcase
    endfunction

    task automatic mq(ref logic [7:0] q[$], input bit flush, push, pop, input logic [7:0] wd,
                      input int cap, ref logic [7:0] rd, ref bit ovr);
        bit pop_ok, push_ok;
        if (flush) begin
            q.delete();
            ovr = 1'b0;
        end else begin
            pop_ok  = pop && (q.size() > 0);
            push_ok = push && ((q.size() < cap) || pop_ok);
            ovr     = push && !push_ok;
            if (pop_ok) rd = q.pop_front();
            if (push_ok) q.push_back(wd);
        end
    endtask

    task automatic compare_all();
        int rl = rxl(), tl = txl();
        bit rh = rq.size() >= rl, th = tq.size() <= tl;
        chk("R3 rx_avail_irq", rx_avail_irq, rh);
        chk("R4 tx_thr_irq", tx_thr_irq, th);
        chk("R9 dma_rx_req_n", dma_rx_req_n, !(m_dm ? rh : rq.size() != 0));
        chk("R9 dma_tx_req_n", dma_tx_req_n, !(m_dm ? th : tq.size() == 0));
        chk("R10 rts_n", rts_n, afc_en && rh);
        chk("R11 tx_ovr", tx_ovr, m_tovr);
        chk("R11 rx_ovr", rx_ovr, m_rovr);
        chk("R2 tx_rdata", tx_rdata, m_trd);
        chk("R2 rx_rdata", rx_rdata, m_rrd);
    endtask

    // Advance model by one cycle with the driven inputs, clock, then compare.
    task automatic step();
        bit ft, fr, flip;
        int cap = m_fen ? D : 1;
        flip = cfg_wr && (cfg_wdata[0] != m_fen);
        ft = (cfg_wr && cfg_wdata[2]) || flip;
        fr = (cfg_wr && cfg_wdata[1]) || flip;
        mq(tq, ft, tx_push, tx_pop, tx_wdata, cap, m_trd, m_tovr);
        mq(rq, fr, rx_push, rx_pop, rx_wdata, cap, m_rrd, m_rovr);
        if (cfg_wr) begin
            m_fen = cfg_wdata[0];
            m_dm  = cfg_wdata[3];
            m_rt  = cfg_wdata[7:6];
            if (prog_en) m_tet = cfg_wdata[5:4];
        end
        @(posedge clk);
        #1;
        compare_all();
        cfg_wr = 0; tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
    endtask

    task automatic wcfg(input logic [7:0] v);
        cfg_wr = 1; cfg_wdata = v; step();
    endtask

    task automatic prx(input logic [7:0] d);
        rx_push = 1; rx_wdata = d; step();
    endtask

    task automatic ptx(input logic [7:0] d);
        tx_push = 1; tx_wdata = d; step();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        chk("R1 rx_avail_irq", rx_avail_irq, 0);
        chk("R1 tx_thr_irq", tx_thr_irq, 1);
        chk("R1 dma_tx_req_n", dma_tx_req_n, 0);
        chk("R1 dma_rx_req_n", dma_rx_req_n, 1);
        chk("R1 rts_n", rts_n, 0);
        chk("R1 ovr", {tx_ovr, rx_ovr}, 0);
        chk("R1 rdata", {tx_rdata, rx_rdata}, 0);

        // R8 disabled queues hold one character
        afc_en = 1;
        prx(8'hA1);
        chk("R8 irq on one char", rx_avail_irq, 1);
        prx(8'hA2);
        chk("R8 second push overruns", rx_ovr, 1);
        rx_pop = 1; step();
        chk("R8 held char", rx_rdata, 8'hA1);
        rx_pop = 1; step();
        chk("R12 empty pop keeps data", rx_rdata, 8'hA1);
        chk("R12 empty pop keeps count", rx_avail_irq, 0);

        // R5 transmit code write ignored while programmable mode is off
        prog_en = 1; wcfg(8'h31);
        prog_en = 0; wcfg(8'h01);
        prog_en = 1;
        repeat (3) ptx(8'h11);
        chk("R5 stored code kept", tx_thr_irq, 1);

        // R7 repeating the enable keeps contents
        prx(8'h21); prx(8'h22);
        wcfg(8'h01);
        chk("R7 same value keeps", rx_avail_irq, 1);

        // R6 clear beats a simultaneous push, then is not sticky
        rx_push = 1; rx_wdata = 8'h33; cfg_wr = 1; cfg_wdata = 8'h03; step();
        chk("R6 clear wins", rx_avail_irq, 0);
        chk("R6 dma released", dma_rx_req_n, 1);
        prx(8'h34);
        chk("R6 self-clearing", rx_avail_irq, 1);

        // R13 and R11 on a full transmit queue
        for (int i = 0; i < D - 3; i++) ptx(8'(i));
        tx_push = 1; tx_wdata = 8'h55; tx_pop = 1; step();
        chk("R13 push+pop on full", tx_ovr, 0);
        chk("R13 oldest out", tx_rdata, 8'h11);
        ptx(8'h66);
        chk("R11 overrun pulse", tx_ovr, 1);
        step();
        chk("R11 pulse ends", tx_ovr, 0);

        // R7 enable change clears both queues
        wcfg(8'h00);
        chk("R7 toggle clears tx", tx_thr_irq, 1);
        chk("R7 toggle clears rx", rx_avail_irq, 0);

        // R9/R10 mode 1 with quarter level
        wcfg(8'h49);
        repeat (3) prx(8'h44);
        chk("R9 below level", dma_rx_req_n, 1);
        prx(8'h45);
        chk("R9 at level", dma_rx_req_n, 0);
        chk("R10 rts at level", rts_n, 1);

        // R3 two-below-full level
        wcfg(8'hC3);
        repeat (D - 3) prx(8'h77);
        chk("R3 below D-2", rx_avail_irq, 0);
        prx(8'h78);
        chk("R3 at D-2", rx_avail_irq, 1);

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int ph = (i / 250) % 3;
            int pp = (ph == 0) ? 70 : (ph == 1) ? 30 : 50;
            tx_push = ($urandom % 100) < pp;
            rx_push = ($urandom % 100) < pp;
            tx_pop  = ($urandom % 100) < (100 - pp);
            rx_pop  = ($urandom % 100) < (100 - pp);
            tx_wdata = 8'($urandom);
            rx_wdata = 8'($urandom);
            if (($urandom % 60) == 0) begin
                cfg_wr = 1;
                cfg_wdata = 8'($urandom);
                cfg_wdata[0] = ($urandom % 8) != 0;
                if (($urandom % 3) != 0) cfg_wdata[2:1] = 2'b00;
            end
            if (($urandom % 200) == 0) prog_en = ~prog_en;
            if (($urandom % 200) == 0) afc_en = ~afc_en;
            step();
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule